// File: doc/BRIEF.md
# Dual Timer and External Interrupt Controller

This block holds two 16-bit up-counting timers and the interrupt logic for two active-low external request pins. All of them share one 8-bit control register. Each timer has its own mode input, which selects a 13-bit counter, a 16-bit counter, or an 8-bit counter that reloads from the timer's high byte. When a timer wraps it sets its overflow flag. The flag drives that timer's interrupt request until an interrupt controller acknowledges it or software writes it to zero.

Each external pin has a type bit. With the type bit set, a falling edge latches an edge flag, and the acknowledge strobe clears that flag. With the type bit clear, the request follows the inverted pin level and nothing is latched. Some pairs of timer modes are not allowed. When the mode inputs form such a pair, the block raises `mode_err` and holds both timers still until a legal pair is applied. Software can preload each counter through a load strobe.

Top module: `dual_timer_ctl`

## Requirements
- R1: After reset the control register reads 0x00, both counters read 0, and all four interrupt requests are low.
- R2: The control register reads, from bit 7 down to bit 0, as: overflow flag 1, run 1, overflow flag 0, run 0, edge flag 1, type 1, edge flag 0, type 0. A write sets the run, type and overflow bits from the written data. The two edge-flag bits ignore writes.
- R3: A timer advances by one on each clock while its run bit is 1 and the mode pair is legal. It holds its value while its run bit is 0. A load strobe (`cnt_we` bit 0 for timer 0, bit 1 for timer 1) replaces the count with `cnt_wdata` and takes priority over counting in that cycle.
- R4: Mode values select the counter behaviour:
  - 0 is a 13-bit counter that wraps from 0x1FFF to 0.
  - 1 is a 16-bit counter that wraps from 0xFFFF to 0.
  - 2 counts the low byte; from 0xFF the low byte reloads with the high byte, so 0x05FF becomes 0x0505.
- R5: On the clock edge where a running timer wraps, its overflow flag becomes 1. `irq_t0` and `irq_t1` equal the respective overflow flags.
- R6: An overflow flag clears on the clock after its acknowledge strobe, or after a control write with 0 in that bit.
- R7: If a timer wraps in the same cycle as its acknowledge or as a software write of 0 to its flag, the flag ends up 1.
- R8: With the type bit set to 1, a high-to-low change of the pin sets the edge flag on the next clock edge, and the request equals that flag. The acknowledge strobe clears the flag. A pin that stays low does not set the flag again.
- R9: With the type bit set to 0, the request equals the inverted pin level in the same cycle, and the edge flag reads 0.
- R10: The mode pair is illegal in three cases, and in each one `mode_err` is 1 and both timers hold even while running:
  - timer 0 is in mode 2 and timer 1 is not in mode 2;
  - timer 0 is in mode 3;
  - timer 1 is in mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_q | output | 8 | Control register read value |
| t0_mode | input | 2 | Timer 0 mode |
| t1_mode | input | 2 | Timer 1 mode |
| cnt_we | input | 2 | Counter load strobes, bit 0 timer 0, bit 1 timer 1 |
| cnt_wdata | input | 16 | Counter load value |
| t0_cnt | output | 16 | Timer 0 count |
| t1_cnt | output | 16 | Timer 1 count |
| int0_n | input | 1 | External request 0, active low, already synchronized |
| int1_n | input | 1 | External request 1, active low, already synchronized |
| ack_t0 | input | 1 | Acknowledge for timer 0 interrupt |
| ack_t1 | input | 1 | Acknowledge for timer 1 interrupt |
| ack_x0 | input | 1 | Acknowledge for external interrupt 0 |
| ack_x1 | input | 1 | Acknowledge for external interrupt 1 |
| irq_t0 | output | 1 | Timer 0 interrupt request |
| irq_t1 | output | 1 | Timer 1 interrupt request |
| irq_x0 | output | 1 | External interrupt 0 request |
| irq_x1 | output | 1 | External interrupt 1 request |
| mode_err | output | 1 | Illegal mode pair indicator |

## Verification
A corrupted count appears on `t0_cnt` or `t1_cnt` on the very next clock. It then shifts the cycle of the wrap, so the overflow flag in `ctl_q` and the timer request rise early or late. A wrong edge-detector history register either misses a falling edge or invents one. That shows up as an edge flag in `ctl_q` and a request one clock after the pin change. A bad flag-priority choice loses the overflow that coincides with an acknowledge, and the request stays low on the clock where it should have risen.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  typedef enum logic [1:0] {
    TM_13  = 2'd0,
    TM_16  = 2'd1,
    TM_8R  = 2'd2,
    TM_RSV = 2'd3
  } tmode_e;

  // control register bit positions
  localparam int B_OVF1 = 7;
  localparam int B_RUN1 = 6;
  localparam int B_OVF0 = 5;
  localparam int B_RUN0 = 4;
  localparam int B_XF1  = 3;
  localparam int B_XT1  = 2;
  localparam int B_XF0  = 1;
  localparam int B_XT0  = 0;

  function automatic logic pair_ok(input logic [1:0] m0, input logic [1:0] m1);
    if (m0 == TM_RSV || m1 == TM_RSV) return 1'b0;
    if (m0 == TM_8R && m1 != TM_8R)   return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/dtc_counter.sv
module dtc_counter
  import dtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [1:0]       mode,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam int HALF = CNT_W / 2;
  localparam int NARROW = CNT_W - 3;

  logic [CNT_W-1:0] cnt_q, cnt_d, step;
  logic             wrap;

  always_comb begin
    step = cnt_q;
    wrap = 1'b0;
    case (tmode_e'(mode))
      TM_13: begin
        wrap = &cnt_q[NARROW-1:0];
        step = '0;
        step[NARROW-1:0] = cnt_q[NARROW-1:0] + 1'b1;
      end
      TM_16: begin
        wrap = &cnt_q;
        step = cnt_q + 1'b1;
      end
      TM_8R: begin
        wrap = &cnt_q[HALF-1:0];
        if (wrap) step = {cnt_q[CNT_W-1:HALF], cnt_q[CNT_W-1:HALF]};
        else      step = {cnt_q[CNT_W-1:HALF], cnt_q[HALF-1:0] + 1'b1};
      end
      default: begin
        wrap = 1'b0;
        step = cnt_q;
      end
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load)    cnt_d = ld_val;
    else if (en) cnt_d = step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
  assign ovf = en & ~load & wrap;

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> (cnt == $past(cnt)));

  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(ld_val)));

endmodule

// File: rtl/dtc_extint.sv
module dtc_extint (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic ack,
  output logic flag,
  output logic irq
);
  logic prev_q, flag_q, flag_d, fall;

  assign fall = prev_q & ~pin_n;

  always_comb begin
    flag_d = flag_q;
    if (!edge_mode) flag_d = 1'b0;
    else if (fall)  flag_d = 1'b1;
    else if (ack)   flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_n;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
  assign irq  = edge_mode ? flag_q : ~pin_n;

  // R8
  fall_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && $fell(pin_n)) |=> flag);

  // R9
  level_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |=> !flag);

endmodule

// File: rtl/dual_timer_ctl.sv
module dual_timer_ctl
  import dtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  output logic [7:0]       ctl_q,
  input  logic [1:0]       t0_mode,
  input  logic [1:0]       t1_mode,
  input  logic [1:0]       cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] t0_cnt,
  output logic [CNT_W-1:0] t1_cnt,
  input  logic             int0_n,
  input  logic             int1_n,
  input  logic             ack_t0,
  input  logic             ack_t1,
  input  logic             ack_x0,
  input  logic             ack_x1,
  output logic             irq_t0,
  output logic             irq_t1,
  output logic             irq_x0,
  output logic             irq_x1,
  output logic             mode_err
);
  localparam int NT = 2;

  logic [NT-1:0] run_q, run_d, ovf_q, ovf_d, typ_q, typ_d;
  logic [NT-1:0] tick_en, wrap_p, ack_t, ack_x, pin_n, xflag, xirq;
  logic [1:0]    modes [NT];
  logic [CNT_W-1:0] cnts [NT];
  logic          ok;

  assign ok       = pair_ok(t0_mode, t1_mode);
  assign mode_err = ~ok;
  assign modes[0] = t0_mode;
  assign modes[1] = t1_mode;
  assign ack_t    = {ack_t1, ack_t0};
  assign ack_x    = {ack_x1, ack_x0};
  assign pin_n    = {int1_n, int0_n};

  generate
    for (genvar i = 0; i < NT; i++) begin : g_ch
      assign tick_en[i] = run_q[i] & ok;

      dtc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (tick_en[i]),
        .load   (cnt_we[i]),
        .ld_val (cnt_wdata),
        .mode   (modes[i]),
        .cnt    (cnts[i]),
        .ovf    (wrap_p[i])
      );

      dtc_extint u_x (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (pin_n[i]),
        .edge_mode (typ_q[i]),
        .ack       (ack_x[i]),
        .flag      (xflag[i]),
        .irq       (xirq[i])
      );
    end
  endgenerate

  always_comb begin
    run_d = run_q;
    ovf_d = ovf_q;
    typ_d = typ_q;
    if (ctl_we) begin
      run_d = {ctl_wdata[B_RUN1], ctl_wdata[B_RUN0]};
      ovf_d = {ctl_wdata[B_OVF1], ctl_wdata[B_OVF0]};
      typ_d = {ctl_wdata[B_XT1],  ctl_wdata[B_XT0]};
    end
    ovf_d = (ovf_d & ~ack_t) | wrap_p;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      ovf_q <= '0;
      typ_q <= '0;
    end else begin
      run_q <= run_d;
      ovf_q <= ovf_d;
      typ_q <= typ_d;
    end
  end

  assign ctl_q  = {ovf_q[1], run_q[1], ovf_q[0], run_q[0],
                   xflag[1], typ_q[1], xflag[0], typ_q[0]};
  assign t0_cnt = cnts[0];
  assign t1_cnt = cnts[1];
  assign irq_t0 = ovf_q[0];
  assign irq_t1 = ovf_q[1];
  assign irq_x0 = xirq[0];
  assign irq_x1 = xirq[1];

  // R7
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_p[0] |=> ctl_q[B_OVF0]);

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_t0 && !wrap_p[0] && !(ctl_we && ctl_wdata[B_OVF0])) |=> !irq_t0);

  // R10
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_err && !cnt_we[1]) |=> $stable(t1_cnt));

  // R5
  irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_t1 == ctl_q[B_OVF1]));

endmodule

// File: tb/sim_dual_timer_ctl.sv
`timescale 1ns/1ps
module sim_dual_timer_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_q;
  logic [1:0] t0_mode = 2'd1, t1_mode = 2'd1;
  logic [1:0] cnt_we = 2'b00;
  logic [15:0] cnt_wdata = 16'h0000;
  logic [15:0] t0_cnt, t1_cnt;
  logic int0_n = 1'b1, int1_n = 1'b1;
  logic ack_t0 = 1'b0, ack_t1 = 1'b0, ack_x0 = 1'b0, ack_x1 = 1'b0;
  logic irq_t0, irq_t1, irq_x0, irq_x1, mode_err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_timer_ctl u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .t0_mode(t0_mode), .t1_mode(t1_mode), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .t0_cnt(t0_cnt), .t1_cnt(t1_cnt), .int0_n(int0_n), .int1_n(int1_n),
    .ack_t0(ack_t0), .ack_t1(ack_t1), .ack_x0(ack_x0), .ack_x1(ack_x1),
    .irq_t0(irq_t0), .irq_t1(irq_t1), .irq_x0(irq_x0), .irq_x1(irq_x1),
    .mode_err(mode_err)
  );

  // {t0_mode, t1_mode, expected mode_err} for R10
  localparam logic [4:0] MODE_TAB [16] = '{
    5'b00_00_0, 5'b00_01_0, 5'b00_10_0, 5'b00_11_1,
    5'b01_00_0, 5'b01_01_0, 5'b01_10_0, 5'b01_11_1,
    5'b10_00_1, 5'b10_01_1, 5'b10_10_0, 5'b10_11_1,
    5'b11_00_1, 5'b11_01_1, 5'b11_10_1, 5'b11_11_1
  };

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_we = 1'b1;
    ctl_wdata = d;
    tick();
    ctl_we = 1'b0;
  endtask

  task automatic load(input logic [1:0] which, input logic [15:0] v);
    cnt_we = which;
    cnt_wdata = v;
    tick();
    cnt_we = 2'b00;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] snap0, snap1;
    tick(3);
    // R1 reset state
    chk("R1 ctl", {24'd0, ctl_q}, 32'h00);
    chk("R1 cnt", {t0_cnt, t1_cnt}, 32'h0);
    chk("R1 irq", {28'd0, irq_t0, irq_t1, irq_x0, irq_x1}, 32'h0);
    rst_n = 1'b1;
    tick();
    chk("R1 after release", {24'd0, ctl_q}, 32'h00);

    // R10 table walk
    for (int i = 0; i < 16; i++) begin
      t0_mode = MODE_TAB[i][4:3];
      t1_mode = MODE_TAB[i][2:1];
      #1;
      chk("R10 table", {31'd0, mode_err}, {31'd0, MODE_TAB[i][0]});
    end

    // R3 R4 R5 16-bit mode overflow
    t0_mode = 2'd1; t1_mode = 2'd1;
    load(2'b01, 16'hFFFE);
    chk("R3 load", {16'd0, t0_cnt}, 32'hFFFE);
    wr_ctl(8'h10);
    chk("R3 no count on run write", {16'd0, t0_cnt}, 32'hFFFE);
    tick();
    chk("R3 count", {16'd0, t0_cnt}, 32'hFFFF);
    tick();
    chk("R4 16-bit wrap", {16'd0, t0_cnt}, 32'h0000);
    chk("R5 flag", {24'd0, ctl_q}, 32'h30);
    chk("R5 irq", {31'd0, irq_t0}, 32'h1);

    // R6 acknowledge clears
    ack_t0 = 1'b1; tick(); ack_t0 = 1'b0;
    chk("R6 ack", {24'd0, ctl_q}, 32'h10);
    chk("R6 irq", {31'd0, irq_t0}, 32'h0);

    // R3 stop
    wr_ctl(8'h00);
    snap0 = t0_cnt;
    tick(3);
    chk("R3 stopped", {16'd0, t0_cnt}, {16'd0, snap0});

    // R7 write-clear collides with overflow
    wr_ctl(8'h10);
    load(2'b01, 16'hFFFF);
    wr_ctl(8'h10);
    chk("R7 write vs overflow", {31'd0, ctl_q[5]}, 32'h1);
    wr_ctl(8'h10);
    chk("R6 sw clear", {31'd0, ctl_q[5]}, 32'h0);
    load(2'b01, 16'hFFFF);
    ack_t0 = 1'b1; tick(); ack_t0 = 1'b0;
    chk("R7 ack vs overflow", {31'd0, irq_t0}, 32'h1);

    // R4 13-bit mode
    t0_mode = 2'd0;
    ctl_we = 1'b1; ctl_wdata = 8'h00; cnt_we = 2'b01; cnt_wdata = 16'h1FFF;
    tick();
    ctl_we = 1'b0; cnt_we = 2'b00;
    wr_ctl(8'h10);
    chk("R4 13-bit preload", {16'd0, t0_cnt}, 32'h1FFF);
    tick();
    chk("R4 13-bit wrap", {16'd0, t0_cnt}, 32'h0000);
    chk("R5 13-bit flag", {31'd0, ctl_q[5]}, 32'h1);

    // R4 auto-reload mode
    wr_ctl(8'h00);
    t0_mode = 2'd2; t1_mode = 2'd2;
    load(2'b10, 16'h05FE);
    wr_ctl(8'h40);
    tick();
    chk("R4 reload pre", {16'd0, t1_cnt}, 32'h05FF);
    tick();
    chk("R4 reload", {16'd0, t1_cnt}, 32'h0505);
    chk("R5 timer1 flag", {24'd0, ctl_q}, 32'hC0);
    chk("R5 irq_t1", {31'd0, irq_t1}, 32'h1);

    // R10 illegal pair holds both
    wr_ctl(8'h50);
    t1_mode = 2'd0;
    #1;
    snap0 = t0_cnt; snap1 = t1_cnt;
    tick(3);
    chk("R10 err", {31'd0, mode_err}, 32'h1);
    chk("R10 hold", {t0_cnt, t1_cnt}, {snap0, snap1});
    t1_mode = 2'd2;
    tick(2);
    chk("R10 resume", {31'd0, t0_cnt != snap0}, 32'h1);
    wr_ctl(8'h00);

    // R8 edge mode
    wr_ctl(8'h05);
    int0_n = 1'b0;
    tick();
    chk("R8 edge flag", {24'd0, ctl_q}, 32'h07);
    chk("R8 irq_x0", {31'd0, irq_x0}, 32'h1);
    ack_x0 = 1'b1; tick(); ack_x0 = 1'b0;
    tick(2);
    chk("R8 ack, low hold no refire", {31'd0, irq_x0}, 32'h0);
    int0_n = 1'b1;
    int1_n = 1'b0;
    tick();
    chk("R8 int1 edge", {31'd0, ctl_q[3]}, 32'h1);
    // R2 edge flag bits ignore writes
    wr_ctl(8'h07);
    chk("R2 xflag write ignored", {24'd0, ctl_q}, 32'h0D);
    ack_x1 = 1'b1; tick(); ack_x1 = 1'b0;
    chk("R8 ack_x1", {31'd0, irq_x1}, 32'h0);
    int1_n = 1'b1;

    // R9 level mode
    wr_ctl(8'h00);
    int0_n = 1'b0;
    #1;
    chk("R9 level irq", {31'd0, irq_x0}, 32'h1);
    tick();
    chk("R9 no latch", {31'd0, ctl_q[1]}, 32'h0);
    int0_n = 1'b1;
    #1;
    chk("R9 level release", {31'd0, irq_x0}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule